// File: doc/BRIEF.md
# Hierarchical Idle State Resolver

This block turns the idle-state wishes of every hardware thread in a small multi-core cluster into one power state per core and one for the whole package. Each core settles on the shallowest state any of its threads will accept. The package then settles on the shallowest state any core has reached, subject to platform permission and a veto on deep entry. A core that heads for a power-removed state first runs a context-save handshake. When it wakes, it raises a power-good view (its power-off line drops) and runs a restore handshake.

States are 3-bit codes in which a larger value always means a deeper state: C0=0, C1=1, C1E=2, C2=3, C3=4, C6=5, C7=6. C2 is internal to the package and cannot come from a thread. Requests are packed per thread: thread t of core c sits at bits [(c*T+t)*3 +: 3], where T is the number of threads per core.

Top module: `idle_resolver`

## Requirements
- R1: One clock edge after a request change, each core's state equals the smallest request code among its threads while that minimum is C3 (4) or shallower.
- R2: When `enhancedEn` is 1, a core whose resolved request is C1 (1) reports C1E (2) instead.
- R3: A thread request of code 3 (the package-only state) is treated as C1, and code 7 is treated as C7 (6).
- R4: A thread's wake counts only if its interrupt is unmasked, or if its request came through the I/O-read path (`ioPath`=1). A masked wake without that path changes nothing.
- R5: A counted wake on any thread of a core drives that core to C0 on the next edge, and drives the package to C0 on that same edge.
- R6: When a core's resolved request is C6 or deeper, the core raises `saveReq` and reports C3 until `saveAck`. On the edge after `saveAck`, it reports the deep state, `powerOff` rises, and `saveReq` falls.
- R7: A counted wake while `saveReq` is high aborts the save: on the next edge `saveReq` falls and the core reports C0.
- R8: A deep core leaves on a counted wake or on a request shallower than C6. On the next edge `powerOff` falls, `restoreReq` rises and the core reports C0. `restoreReq` stays high until `restoreAck`, after which the core follows its request again.
- R9: The package state is C0 on the edge after any core reports a state below C3, or while `platformGrant` is 0.
- R10: If all cores report C3 or deeper, `platformGrant` is 1 and `deepVeto` is 1, the package enters C2 (3) on the next edge.
- R11: Otherwise the package takes the shallowest core state on the next edge. It moves straight between low-power package states without passing through C0.
- R12: After reset every core and the package report C0, and `saveReq`, `restoreReq` and `powerOff` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| threadReq | input | NUM_CORES*THREADS_PER_CORE*3 | Per-thread requested state codes |
| enhancedEn | input | 1 | Promote C1 to C1E |
| wakeEvt | input | NUM_CORES*THREADS_PER_CORE | Per-thread interrupt/wake event |
| intMasked | input | NUM_CORES*THREADS_PER_CORE | Per-thread interrupt mask |
| ioPath | input | NUM_CORES*THREADS_PER_CORE | Request came via the I/O-read path |
| platformGrant | input | 1 | Platform permits package low power |
| deepVeto | input | 1 | Latency or timer constraint forbids deeper than C2 |
| saveAck | input | NUM_CORES | Context-save done, per core |
| restoreAck | input | NUM_CORES | Context-restore done, per core |
| coreState | output | NUM_CORES*3 | Resolved core states |
| pkgState | output | 3 | Resolved package state |
| saveReq | output | NUM_CORES | Context-save request strobe |
| restoreReq | output | NUM_CORES | Context-restore request strobe |
| powerOff | output | NUM_CORES | Core voltage-off indication |

## Verification
The assertions assume that `saveAck` is only meaningful while `saveReq` is high, and `restoreAck` only while `restoreReq` is high. They also assume that `deepVeto` and `platformGrant` are held steady at reset. The stimulus raises each acknowledge for a single cycle, and only while the matching request is up. It keeps every input quiet during reset, and it changes inputs only on the falling edge, so each expected state can be stated exactly one or two edges later.

// File: rtl/idle_resolver_pkg.sv
package idle_resolver_pkg;

  localparam int StW = 3;

  localparam logic [StW-1:0] ST_C0  = 3'd0;
  localparam logic [StW-1:0] ST_C1  = 3'd1;
  localparam logic [StW-1:0] ST_C1E = 3'd2;
  localparam logic [StW-1:0] ST_C2  = 3'd3;
  localparam logic [StW-1:0] ST_C3  = 3'd4;
  localparam logic [StW-1:0] ST_C6  = 3'd5;
  localparam logic [StW-1:0] ST_C7  = 3'd6;

  typedef enum logic [1:0] {
    MODE_ACTIVE,
    MODE_SAVING,
    MODE_DEEP,
    MODE_RESTORING
  } coreMode_e;

  // strobes from the sequencer into the state registers, at most one per core
  typedef struct packed {
    logic followTarget;
    logic enterSave;
    logic enterDeep;
    logic wakeC0;
  } coreStrobe_t;

  // map raw thread codes onto the legal request set
  function automatic logic [StW-1:0] cleanReq(input logic [StW-1:0] raw);
    logic [StW-1:0] v;
    case (raw)
      ST_C2:   v = ST_C1;
      3'd7:    v = ST_C7;
      default: v = raw;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/idle_min_reduce.sv
module idle_min_reduce #(
  parameter int N = 2,
  parameter int W = 3
) (
  input  logic [N*W-1:0] vals,
  output logic [W-1:0]   minVal
);
  always_comb begin
    minVal = vals[W-1:0];
    for (int i = 1; i < N; i++) begin
      if (vals[i*W +: W] < minVal) minVal = vals[i*W +: W];
    end
  end
endmodule

// File: rtl/idle_datapath.sv
module idle_datapath
  import idle_resolver_pkg::*;
#(
  parameter int NC = 2,
  parameter int NT = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NC*NT*StW-1:0]  threadReq,
  input  logic                  enhancedEn,
  input  logic [NC*NT-1:0]      wakeEvt,
  input  logic [NC*NT-1:0]      intMasked,
  input  logic [NC*NT-1:0]      ioPath,
  input  logic                  platformGrant,
  input  logic                  deepVeto,
  input  coreStrobe_t [NC-1:0]  strobe,
  output logic [NC*StW-1:0]     coreTarget,
  output logic [NC-1:0]         coreWake,
  output logic [NC*StW-1:0]     coreState,
  output logic [StW-1:0]        pkgState
);
  logic [NC-1:0][StW-1:0] coreQ;
  logic [StW-1:0]         pkgQ;
  logic [StW-1:0]         shallowCore;
  logic [StW-1:0]         pkgNext;
  logic                   anyWake;

  for (genvar c = 0; c < NC; c++) begin : g_core
    logic [NT*StW-1:0] cleaned;
    logic [StW-1:0]    rawMin;
    logic [NT-1:0]     thrWake;

    for (genvar t = 0; t < NT; t++) begin : g_thr
      assign cleaned[t*StW +: StW] = cleanReq(threadReq[(c*NT+t)*StW +: StW]);
      // a masked interrupt still wakes a thread parked through the I/O path (R4)
      assign thrWake[t] = wakeEvt[c*NT+t] & (~intMasked[c*NT+t] | ioPath[c*NT+t]);
    end

    idle_min_reduce #(.N(NT), .W(StW)) u_thrMin (
      .vals   (cleaned),
      .minVal (rawMin)
    );

    assign coreTarget[c*StW +: StW] = (enhancedEn && rawMin == ST_C1) ? ST_C1E : rawMin;
    assign coreWake[c]              = |thrWake;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        coreQ[c] <= ST_C0;
      end else if (strobe[c].wakeC0) begin
        coreQ[c] <= ST_C0;
      end else if (strobe[c].enterSave) begin
        coreQ[c] <= ST_C3;
      end else if (strobe[c].followTarget || strobe[c].enterDeep) begin
        coreQ[c] <= coreTarget[c*StW +: StW];
      end
    end

    assign coreState[c*StW +: StW] = coreQ[c];

    p_strobe_excl_r6 : assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(strobe[c]));

    p_core_wake_r5 : assert property (@(posedge clk) disable iff (!rstN)
      coreWake[c] |=> coreQ[c] == ST_C0);
  end

  idle_min_reduce #(.N(NC), .W(StW)) u_coreMin (
    .vals   (coreState),
    .minVal (shallowCore)
  );

  assign anyWake = |coreWake;

  always_comb begin
    if (anyWake || !platformGrant || shallowCore < ST_C3) begin
      pkgNext = ST_C0;
    end else if (deepVeto) begin
      pkgNext = ST_C2;
    end else begin
      pkgNext = shallowCore;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pkgQ <= ST_C0;
    else       pkgQ <= pkgNext;
  end

  assign pkgState = pkgQ;

  p_pkg_wake_r5 : assert property (@(posedge clk) disable iff (!rstN)
    anyWake |=> pkgQ == ST_C0);

  p_pkg_grant_r9 : assert property (@(posedge clk) disable iff (!rstN)
    !platformGrant |=> pkgQ == ST_C0);

  p_pkg_c2_r10 : assert property (@(posedge clk) disable iff (!rstN)
    pkgQ == ST_C2 |-> $past(deepVeto && platformGrant));

endmodule

// File: rtl/idle_control.sv
module idle_control
  import idle_resolver_pkg::*;
#(
  parameter int NC = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NC*StW-1:0]    coreTarget,
  input  logic [NC-1:0]        coreWake,
  input  logic [NC-1:0]        saveAck,
  input  logic [NC-1:0]        restoreAck,
  output coreStrobe_t [NC-1:0] strobe,
  output logic [NC-1:0]        saveReq,
  output logic [NC-1:0]        restoreReq,
  output logic [NC-1:0]        powerOff
);
  for (genvar c = 0; c < NC; c++) begin : g_seq
    coreMode_e      modeQ, modeNext;
    coreStrobe_t    stb;
    logic [StW-1:0] tgt;
    logic           wantDeep;

    assign tgt      = coreTarget[c*StW +: StW];
    assign wantDeep = tgt >= ST_C6;

    always_comb begin
      modeNext = modeQ;
      stb      = '0;
      unique case (modeQ)
        MODE_ACTIVE: begin
          if (coreWake[c]) begin
            stb.wakeC0 = 1'b1;
          end else if (wantDeep) begin
            stb.enterSave = 1'b1;
            modeNext      = MODE_SAVING;
          end else begin
            stb.followTarget = 1'b1;
          end
        end
        MODE_SAVING: begin
          if (coreWake[c]) begin
            stb.wakeC0 = 1'b1;
            modeNext   = MODE_ACTIVE;
          end else if (!wantDeep) begin
            stb.followTarget = 1'b1;
            modeNext         = MODE_ACTIVE;
          end else if (saveAck[c]) begin
            stb.enterDeep = 1'b1;
            modeNext      = MODE_DEEP;
          end
        end
        MODE_DEEP: begin
          if (coreWake[c] || !wantDeep) begin
            stb.wakeC0 = 1'b1;
            modeNext   = MODE_RESTORING;
          end else begin
            stb.enterDeep = 1'b1;
          end
        end
        MODE_RESTORING: begin
          if (restoreAck[c]) modeNext = MODE_ACTIVE;
        end
        default: modeNext = MODE_ACTIVE;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) modeQ <= MODE_ACTIVE;
      else       modeQ <= modeNext;
    end

    assign strobe[c]     = stb;
    assign saveReq[c]    = modeQ == MODE_SAVING;
    assign restoreReq[c] = modeQ == MODE_RESTORING;
    assign powerOff[c]   = modeQ == MODE_DEEP;

    p_off_after_save_r6 : assert property (@(posedge clk) disable iff (!rstN)
      $rose(powerOff[c]) |-> $past(saveAck[c]));

    p_save_abort_r7 : assert property (@(posedge clk) disable iff (!rstN)
      (saveReq[c] && coreWake[c]) |=> !saveReq[c]);

    p_restore_hold_r8 : assert property (@(posedge clk) disable iff (!rstN)
      (restoreReq[c] && !restoreAck[c]) |=> restoreReq[c]);

    p_power_first_r8 : assert property (@(posedge clk) disable iff (!rstN)
      $fell(powerOff[c]) |-> restoreReq[c]);
  end
endmodule

// File: rtl/idle_resolver.sv
module idle_resolver
  import idle_resolver_pkg::*;
#(
  parameter int NUM_CORES        = 2,
  parameter int THREADS_PER_CORE = 2
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic [NUM_CORES*THREADS_PER_CORE*3-1:0]   threadReq,
  input  logic                                      enhancedEn,
  input  logic [NUM_CORES*THREADS_PER_CORE-1:0]     wakeEvt,
  input  logic [NUM_CORES*THREADS_PER_CORE-1:0]     intMasked,
  input  logic [NUM_CORES*THREADS_PER_CORE-1:0]     ioPath,
  input  logic                                      platformGrant,
  input  logic                                      deepVeto,
  input  logic [NUM_CORES-1:0]                      saveAck,
  input  logic [NUM_CORES-1:0]                      restoreAck,
  output logic [NUM_CORES*3-1:0]                    coreState,
  output logic [2:0]                                pkgState,
  output logic [NUM_CORES-1:0]                      saveReq,
  output logic [NUM_CORES-1:0]                      restoreReq,
  output logic [NUM_CORES-1:0]                      powerOff
);
  coreStrobe_t [NUM_CORES-1:0] strobe;
  logic [NUM_CORES*StW-1:0]    coreTarget;
  logic [NUM_CORES-1:0]        coreWake;

  idle_datapath #(.NC(NUM_CORES), .NT(THREADS_PER_CORE)) u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .threadReq     (threadReq),
    .enhancedEn    (enhancedEn),
    .wakeEvt       (wakeEvt),
    .intMasked     (intMasked),
    .ioPath        (ioPath),
    .platformGrant (platformGrant),
    .deepVeto      (deepVeto),
    .strobe        (strobe),
    .coreTarget    (coreTarget),
    .coreWake      (coreWake),
    .coreState     (coreState),
    .pkgState      (pkgState)
  );

  idle_control #(.NC(NUM_CORES)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .coreTarget (coreTarget),
    .coreWake   (coreWake),
    .saveAck    (saveAck),
    .restoreAck (restoreAck),
    .strobe     (strobe),
    .saveReq    (saveReq),
    .restoreReq (restoreReq),
    .powerOff   (powerOff)
  );
endmodule

// File: tb/idle_resolver_bench.sv
module idle_resolver_bench;
  localparam int NC = 2;
  localparam int NT = 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [NC*NT*3-1:0] threadReq = '0;
  logic             enhancedEn = 1'b0;
  logic [NC*NT-1:0] wakeEvt = '0;
  logic [NC*NT-1:0] intMasked = '0;
  logic [NC*NT-1:0] ioPath = '0;
  logic             platformGrant = 1'b0;
  logic             deepVeto = 1'b0;
  logic [NC-1:0]    saveAck = '0;
  logic [NC-1:0]    restoreAck = '0;
  logic [NC*3-1:0]  coreState;
  logic [2:0]       pkgState;
  logic [NC-1:0]    saveReq, restoreReq, powerOff;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int         due;
    logic [2:0] c0, c1, pk;
    logic [1:0] off, sr, rr;
    string      tag;
  } expItem_t;

  expItem_t scoreQ[$];

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) cyc <= cyc + 1;

  idle_resolver #(.NUM_CORES(NC), .THREADS_PER_CORE(NT)) u_idle_resolver (
    .clk(clk), .rstN(rstN), .threadReq(threadReq), .enhancedEn(enhancedEn),
    .wakeEvt(wakeEvt), .intMasked(intMasked), .ioPath(ioPath),
    .platformGrant(platformGrant), .deepVeto(deepVeto),
    .saveAck(saveAck), .restoreAck(restoreAck),
    .coreState(coreState), .pkgState(pkgState),
    .saveReq(saveReq), .restoreReq(restoreReq), .powerOff(powerOff)
  );

  // monitor: pops expectations that fall due and compares at the falling edge
  always @(negedge clk) begin
    while (scoreQ.size() > 0 && scoreQ[0].due == cyc) begin
      expItem_t e;
      e = scoreQ.pop_front();
      total++;
      if (coreState[2:0] !== e.c0 || coreState[5:3] !== e.c1 || pkgState !== e.pk ||
          powerOff !== e.off || saveReq !== e.sr || restoreReq !== e.rr) begin
        bad++;
        $display("FAIL %s: got c0=%0d c1=%0d pkg=%0d off=%b sreq=%b rreq=%b, expected c0=%0d c1=%0d pkg=%0d off=%b sreq=%b rreq=%b",
                 e.tag, coreState[2:0], coreState[5:3], pkgState, powerOff, saveReq, restoreReq,
                 e.c0, e.c1, e.pk, e.off, e.sr, e.rr);
      end
    end
  end

  task automatic setCore(input int c, input logic [2:0] a, input logic [2:0] b);
    threadReq[(c*NT+0)*3 +: 3] = a;
    threadReq[(c*NT+1)*3 +: 3] = b;
  endtask

  // driver: queue what the outputs must be after the next rising edge, then advance
  task automatic step(input logic [2:0] c0, input logic [2:0] c1, input logic [2:0] pk,
                      input logic [1:0] off, input logic [1:0] sr, input logic [1:0] rr,
                      input string tag);
    expItem_t e;
    e.due = cyc + 1; e.c0 = c0; e.c1 = c1; e.pk = pk;
    e.off = off; e.sr = sr; e.rr = rr; e.tag = tag;
    scoreQ.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(0, 0, 0, 2'b00, 2'b00, 2'b00, "R12 reset state");

    platformGrant = 1'b1;
    setCore(0, 3'd1, 3'd4); setCore(1, 3'd4, 3'd4);
    step(1, 4, 0, 2'b00, 2'b00, 2'b00, "R1 shallowest thread wins");
    step(1, 4, 0, 2'b00, 2'b00, 2'b00, "R9 core in C1 keeps package C0");
    enhancedEn = 1'b1;
    step(2, 4, 0, 2'b00, 2'b00, 2'b00, "R2 C1 promoted to C1E");
    setCore(0, 3'd4, 3'd6);
    step(4, 4, 0, 2'b00, 2'b00, 2'b00, "R1 core follows C3");
    step(4, 4, 4, 2'b00, 2'b00, 2'b00, "R11 package C3");
    deepVeto = 1'b1;
    step(4, 4, 3, 2'b00, 2'b00, 2'b00, "R10 veto gives package C2");
    deepVeto = 1'b0; platformGrant = 1'b0;
    step(4, 4, 0, 2'b00, 2'b00, 2'b00, "R9 no grant gives package C0");
    platformGrant = 1'b1;
    step(4, 4, 4, 2'b00, 2'b00, 2'b00, "R11 package C3 from C0");

    setCore(1, 3'd7, 3'd7); setCore(0, 3'd3, 3'd4);
    step(2, 4, 4, 2'b00, 2'b10, 2'b00, "R3 codes 3 and 7 mapped; R6 save started");
    step(2, 4, 0, 2'b00, 2'b10, 2'b00, "R6 save held without ack");
    setCore(0, 3'd4, 3'd4);
    step(4, 4, 0, 2'b00, 2'b10, 2'b00, "R6 core reports C3 while saving");
    step(4, 4, 4, 2'b00, 2'b10, 2'b00, "R11 package C3 during save");
    saveAck = 2'b10;
    step(4, 6, 4, 2'b10, 2'b00, 2'b00, "R6 ack then deep and power off");
    saveAck = 2'b00;
    step(4, 6, 4, 2'b10, 2'b00, 2'b00, "R11 package at shallowest core");

    setCore(0, 3'd5, 3'd6);
    step(4, 6, 4, 2'b10, 2'b01, 2'b00, "R6 core0 save started");
    saveAck = 2'b01;
    step(5, 6, 4, 2'b11, 2'b00, 2'b00, "R6 core0 enters C6");
    saveAck = 2'b00;
    step(5, 6, 5, 2'b11, 2'b00, 2'b00, "R11 package C3 to C6 without C0");
    setCore(0, 3'd6, 3'd6);
    step(6, 6, 5, 2'b11, 2'b00, 2'b00, "R6 deep core tracks C7");
    step(6, 6, 6, 2'b11, 2'b00, 2'b00, "R11 package C6 to C7 without C0");

    wakeEvt = 4'b0001; intMasked = 4'b0001;
    step(6, 6, 6, 2'b11, 2'b00, 2'b00, "R4 masked wake ignored");
    ioPath = 4'b0001;
    step(0, 6, 0, 2'b10, 2'b00, 2'b01, "R4 I/O path wake; R5 core and package C0; R8 restore");
    wakeEvt = '0; intMasked = '0; ioPath = '0;
    step(0, 6, 0, 2'b10, 2'b00, 2'b01, "R8 restore held until ack");
    restoreAck = 2'b01; setCore(0, 3'd0, 3'd0);
    step(0, 6, 0, 2'b10, 2'b00, 2'b00, "R8 restore ends on ack");
    restoreAck = 2'b00;
    step(0, 6, 0, 2'b10, 2'b00, 2'b00, "R1 core follows C0 after restore");

    setCore(0, 3'd5, 3'd5);
    step(4, 6, 0, 2'b10, 2'b01, 2'b00, "R6 second save started");
    wakeEvt = 4'b0010;
    step(0, 6, 0, 2'b10, 2'b00, 2'b00, "R7 wake aborts save");
    wakeEvt = '0; setCore(0, 3'd0, 3'd0);
    step(0, 6, 0, 2'b10, 2'b00, 2'b00, "R7 core stays C0 after abort");

    setCore(1, 3'd0, 3'd1);
    step(0, 0, 0, 2'b00, 2'b00, 2'b10, "R8 shallow request exits deep");
    restoreAck = 2'b10;
    step(0, 0, 0, 2'b00, 2'b00, 2'b00, "R8 core1 restore acked");
    restoreAck = 2'b00;
    step(0, 0, 0, 2'b00, 2'b00, 2'b00, "R1 core1 follows C0");

    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got no completion, expected finish within 5000 cycles");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule